// File: doc/BRIEF.md
# Protocol Discovery Enumerator

This engine walks the mandatory discovery protocol of a request/response mailbox and builds a small table of the protocols the mailbox offers. A `start` pulse clears the table and sends a discovery request for index 0. Each response names one supported protocol as a vendor ID and a type, together with the index to ask for next. The engine stores the pair, then asks for that next index. A next index of 0 ends the walk. The mailbox transport is reached through a plain task handshake: a request is offered until the port accepts it, and the response comes back later as a single-cycle strobe.

Once the table is built, the block answers lookup queries. A vendor ID and type are presented on the query bus, and one cycle later a hit flag reports whether that pair is supported. The discovery protocol itself (vendor 0x0001, type 0) always hits, whatever the table holds. A malformed response, a transport error or a table overflow ends the walk with the error flag set. The entries stored before the failure stay valid for lookup.

Top module: `disc_enum`

## Requirements
- R1: After reset, `done`, `err`, `hit` and `req_valid` are 0 and `proto_count` is 0.
- R2: In every request the vendor field is 0x0001 and the type field is 0. The payload dword carries the requested index in bits 7:0 with bits 31:8 at zero. The first request of a walk asks for index 0. A request stays asserted with a stable payload until `req_ready` is seen.
- R3: An accepted response payload is decoded as follows: vendor ID in bits 15:0, protocol type in bits 23:16, next index in bits 31:24. Each good response stores its pair and raises `proto_count` by one.
- R4: The index of each following request equals the next index of the previous response. A next index of 0 ends the walk with `done`=1 and no further request.
- R5: A response whose `rsp_len` (payload length in dwords) is not exactly 1 sets `err`, stores nothing and stops the walk. `done` and `err` are never both 1.
- R6: A response with `rsp_err`=1 sets `err`, stores nothing and stops the walk.
- R7: A good response that arrives while `proto_count` equals DEPTH is an overflow. It sets `err`, stops the walk, and leaves `proto_count` at DEPTH.
- R8: One cycle after a query, `hit` is 1 exactly when the queried vendor and type match an entry among the first `proto_count` stored, or when R9 applies.
- R9: A query for vendor 0x0001 and type 0 always gives `hit`=1 on the next cycle.
- R10: `start` is ignored while a walk is running. A `start` when idle clears `done`, `err` and `proto_count` and begins a new walk at index 0.
- R11: `rsp_valid` has no effect unless the engine is waiting for a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new walk (when idle) |
| req_valid | output | 1 | Discovery request offered to the mailbox |
| req_ready | input | 1 | Mailbox accepts the request |
| req_vid | output | 16 | Request header vendor ID (0x0001) |
| req_type | output | 8 | Request header object type (0) |
| req_dword | output | 32 | Request payload, index in bits 7:0 |
| rsp_valid | input | 1 | Response strobe |
| rsp_word | input | 32 | First response payload dword |
| rsp_len | input | LEN_W | Response payload length in dwords |
| rsp_err | input | 1 | Transport error for this response |
| qry_vid | input | 16 | Lookup vendor ID |
| qry_type | input | 8 | Lookup protocol type |
| done | output | 1 | Walk ended normally |
| err | output | 1 | Walk ended with an error |
| proto_count | output | CNT_W | Number of stored protocols |
| hit | output | 1 | Lookup result for the previous cycle's query |

## Verification
The walk is driven with a chain that skips indices (0, 2, 5). This exposes any engine that counts up instead of following the next index, and any decoder that takes the fields from the wrong bit positions. A chain one entry longer than the table separates a correct overflow stop from silent wrap-around. Length and transport failures are injected mid-walk to show that nothing is stored afterwards. Stray `start` and `rsp_valid` pulses land in the idle, issue and wait phases. The lookups cover stored pairs, the discovery pair on an empty table, and near-miss pairs that differ in only the type or the vendor.

// File: rtl/disc_pkg.sv
package disc_pkg;
  localparam logic [15:0] STD_VID   = 16'h0001;
  localparam logic [7:0]  DISC_TYPE = 8'h00;
  localparam int          IDX_W     = 8;

  typedef struct packed {
    logic [15:0] vid;
    logic [7:0]  ptype;
  } proto_t;

  typedef enum logic [1:0] {W_IDLE, W_ISSUE, W_AWAIT} walk_st_t;

  function automatic logic [31:0] req_word(input logic [IDX_W-1:0] idx);
    return {24'h000000, idx};
  endfunction

  function automatic proto_t rsp_proto(input logic [31:0] w);
    proto_t p;
    p.vid   = w[15:0];
    p.ptype = w[23:16];
    return p;
  endfunction

  function automatic logic [IDX_W-1:0] rsp_next(input logic [31:0] w);
    return w[31:24];
  endfunction

  function automatic logic is_disc(input proto_t p);
    return (p.vid == STD_VID) && (p.ptype == DISC_TYPE);
  endfunction
endpackage

// File: rtl/disc_rsp_dec.sv
module disc_rsp_dec
  import disc_pkg::*;
#(
  parameter int LEN_W = 18
) (
  input  logic [31:0]      rsp_word,
  input  logic [LEN_W-1:0] rsp_len,
  output proto_t           entry,
  output logic [IDX_W-1:0] next_idx,
  output logic             len_ok
);
  always_comb begin
    entry    = rsp_proto(rsp_word);
    next_idx = rsp_next(rsp_word);
    len_ok   = (rsp_len == LEN_W'(1));
  end
endmodule

// File: rtl/disc_walk_fsm.sv
module disc_walk_fsm
  import disc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             req_ready,
  input  logic             rsp_valid,
  input  logic             rsp_err,
  input  logic             len_ok,
  input  logic [IDX_W-1:0] next_idx,
  output logic             req_valid,
  output logic [IDX_W-1:0] cur_idx,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [CNT_W-1:0] count,
  output logic             done,
  output logic             err,
  output logic             ev_store,
  output logic             ev_finish,
  output logic             ev_overflow,
  output logic             ev_fail
);
  walk_st_t         st_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q, err_q;
  logic             take_rsp, ev_start, ev_issue, full;

  always_comb begin
    take_rsp    = (st_q == W_AWAIT) && rsp_valid;
    full        = (cnt_q == CNT_W'(DEPTH));
    ev_start    = (st_q == W_IDLE) && start;
    ev_issue    = (st_q == W_ISSUE) && req_ready;
    ev_fail     = take_rsp && (rsp_err || !len_ok);
    ev_overflow = take_rsp && !rsp_err && len_ok && full;
    ev_store    = take_rsp && !rsp_err && len_ok && !full;
    ev_finish   = ev_store && (next_idx == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= W_IDLE;
      idx_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      unique case (st_q)
        W_IDLE: if (ev_start) begin
          st_q   <= W_ISSUE;
          idx_q  <= '0;
          cnt_q  <= '0;
          done_q <= 1'b0;
          err_q  <= 1'b0;
        end
        W_ISSUE: if (ev_issue) st_q <= W_AWAIT;
        W_AWAIT: begin
          if (ev_fail || ev_overflow) begin
            err_q <= 1'b1;
            st_q  <= W_IDLE;
          end else if (ev_store) begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (ev_finish) begin
              done_q <= 1'b1;
              st_q   <= W_IDLE;
            end else begin
              idx_q <= next_idx;
              st_q  <= W_ISSUE;
            end
          end
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end

  assign req_valid = (st_q == W_ISSUE);
  assign cur_idx   = idx_q;
  assign wr_en     = ev_store;
  assign wr_addr   = cnt_q[AW-1:0];
  assign count     = cnt_q;
  assign done      = done_q;
  assign err       = err_q;
endmodule

// File: rtl/disc_table.sv
module disc_table
  import disc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  proto_t           wr_data,
  input  logic [CNT_W-1:0] count,
  input  proto_t           qry,
  output logic             hit
);
  logic [DEPTH-1:0] match;
  logic             hit_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    proto_t ent_q;
    always_ff @(posedge clk) begin
      if (!rst_n) ent_q <= '0;
      else if (wr_en && (wr_addr == AW'(i))) ent_q <= wr_data;
    end
    assign match[i] = (CNT_W'(i) < count) && (ent_q == qry);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= (|match) || is_disc(qry);
  end

  assign hit = hit_q;
endmodule

// File: rtl/disc_enum.sv
module disc_enum
  import disc_pkg::*;
#(
  parameter  int DEPTH = 8,
  parameter  int LEN_W = 18,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [15:0]      req_vid,
  output logic [7:0]       req_type,
  output logic [31:0]      req_dword,
  input  logic             rsp_valid,
  input  logic [31:0]      rsp_word,
  input  logic [LEN_W-1:0] rsp_len,
  input  logic             rsp_err,
  input  logic [15:0]      qry_vid,
  input  logic [7:0]       qry_type,
  output logic             done,
  output logic             err,
  output logic [CNT_W-1:0] proto_count,
  output logic             hit
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  proto_t           dec_entry, qry;
  logic [IDX_W-1:0] dec_next, cur_idx;
  logic             dec_len_ok, wr_en;
  logic [AW-1:0]    wr_addr;
  logic             ev_store, ev_finish, ev_overflow, ev_fail;

  disc_rsp_dec #(.LEN_W(LEN_W)) u_dec (
    .rsp_word (rsp_word),
    .rsp_len  (rsp_len),
    .entry    (dec_entry),
    .next_idx (dec_next),
    .len_ok   (dec_len_ok)
  );

  disc_walk_fsm #(.DEPTH(DEPTH), .CNT_W(CNT_W), .AW(AW)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .len_ok      (dec_len_ok),
    .next_idx    (dec_next),
    .req_valid   (req_valid),
    .cur_idx     (cur_idx),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .count       (proto_count),
    .done        (done),
    .err         (err),
    .ev_store    (ev_store),
    .ev_finish   (ev_finish),
    .ev_overflow (ev_overflow),
    .ev_fail     (ev_fail)
  );

  assign qry.vid   = qry_vid;
  assign qry.ptype = qry_type;

  disc_table #(.DEPTH(DEPTH), .CNT_W(CNT_W), .AW(AW)) u_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (dec_entry),
    .count   (proto_count),
    .qry     (qry),
    .hit     (hit)
  );

  assign req_vid   = STD_VID;
  assign req_type  = DISC_TYPE;
  assign req_dword = req_word(cur_idx);
endmodule

// File: rtl/disc_enum_chk.sv
module disc_enum_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [15:0]      req_vid,
  input logic [7:0]       req_type,
  input logic [31:0]      req_dword,
  input logic [15:0]      qry_vid,
  input logic [7:0]       qry_type,
  input logic             done,
  input logic             err,
  input logic [CNT_W-1:0] proto_count,
  input logic             hit,
  input logic             ev_store,
  input logic             ev_finish,
  input logic             ev_overflow,
  input logic             ev_fail
);
  p_req_format_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_vid == 16'h0001) && (req_type == 8'h00) && (req_dword[31:8] == 24'h0));

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_dword)));

  p_store_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_store |=> (proto_count == $past(proto_count) + CNT_W'(1)));

  p_finish_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_finish |=> (done && !req_valid));

  p_done_err_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  p_fail_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fail |=> (err && !req_valid && $stable(proto_count)));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    proto_count <= CNT_W'(DEPTH));

  p_overflow_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overflow |=> (err && $stable(proto_count)));

  p_self_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((qry_vid == 16'h0001) && (qry_type == 8'h00)) |=> hit);
endmodule

bind disc_enum disc_enum_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_vid     (req_vid),
  .req_type    (req_type),
  .req_dword   (req_dword),
  .qry_vid     (qry_vid),
  .qry_type    (qry_type),
  .done        (done),
  .err         (err),
  .proto_count (proto_count),
  .hit         (hit),
  .ev_store    (ev_store),
  .ev_finish   (ev_finish),
  .ev_overflow (ev_overflow),
  .ev_fail     (ev_fail)
);

// File: tb/sim_disc_enum.sv
`timescale 1ns/1ps
module sim_disc_enum;
  localparam int TB_DEPTH = 4;
  localparam int LEN_W    = 18;
  localparam int CNT_W    = $clog2(TB_DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0, req_ready = 1'b0, rsp_valid = 1'b0, rsp_err = 1'b0;
  logic [31:0]      rsp_word = '0;
  logic [LEN_W-1:0] rsp_len = '0;
  logic [15:0]      qry_vid = 16'hFFFF;
  logic [7:0]       qry_type = 8'hFF;
  logic             req_valid, done, err, hit;
  logic [15:0]      req_vid;
  logic [7:0]       req_type;
  logic [31:0]      req_dword;
  logic [CNT_W-1:0] proto_count;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2 clk = ~clk;

  disc_enum #(.DEPTH(TB_DEPTH), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .req_valid(req_valid), .req_ready(req_ready),
    .req_vid(req_vid), .req_type(req_type), .req_dword(req_dword), .rsp_valid(rsp_valid),
    .rsp_word(rsp_word), .rsp_len(rsp_len), .rsp_err(rsp_err), .qry_vid(qry_vid),
    .qry_type(qry_type), .done(done), .err(err), .proto_count(proto_count), .hit(hit)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: 0 idle, 1 asking, 2 waiting
  int      m_phase = 0, m_idx = 0;
  bit      m_done = 0, m_err = 0, m_hit = 0;
  int      m_list[$];

  function automatic bit m_lookup(input logic [15:0] v, input logic [7:0] t);
    if (v == 16'd1 && t == 8'd0) return 1'b1;
    foreach (m_list[k]) if (m_list[k] == {t, v}) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_idx = 0; m_done = 0; m_err = 0; m_hit = 0; m_list.delete();
    end else begin
      m_hit = m_lookup(qry_vid, qry_type);
      if (m_phase == 0) begin
        if (start) begin
          m_list.delete(); m_idx = 0; m_done = 0; m_err = 0; m_phase = 1;
        end
      end else if (m_phase == 1) begin
        if (req_ready) m_phase = 2;
      end else if (rsp_valid) begin
        if (rsp_err || rsp_len != 1 || m_list.size() == TB_DEPTH) begin
          m_err = 1; m_phase = 0;
        end else begin
          m_list.push_back({rsp_word[23:16], rsp_word[15:0]});
          if (rsp_word[31:24] == 8'd0) begin
            m_done = 1; m_phase = 0;
          end else begin
            m_idx = rsp_word[31:24]; m_phase = 1;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(done == m_done, "R4", "cmp done", done, m_done);
      check(err == m_err, "R5", "cmp err", err, m_err);
      check(proto_count == m_list.size(), "R3", "cmp count", proto_count, m_list.size());
      check(req_valid == (m_phase == 1), "R2", "cmp req_valid", req_valid, m_phase == 1);
      if (m_phase == 1)
        check(req_dword == m_idx, "R2", "cmp req_dword", req_dword, m_idx);
      check(hit == m_hit, "R8", "cmp hit", hit, m_hit);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog: actual=%0d expected<50000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [31:0] mk(input logic [15:0] v, input logic [7:0] t, input logic [7:0] nx);
    return {nx, t, v};
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic pulse_start();
    start = 1'b1; tick(); start = 1'b0;
  endtask

  task automatic answer(input logic [31:0] w, input int len, input bit xerr,
                        input logic [7:0] exp_idx, input string tag);
    int guard = 0;
    while (!req_valid && guard < 200) begin tick(); guard++; end
    check(req_valid && req_dword == {24'h0, exp_idx}, tag, "request index", req_dword, exp_idx);
    tick(); tick();          // hold request unanswered for two cycles
    req_ready = 1'b1; tick(); req_ready = 1'b0;
    tick();
    rsp_word = w; rsp_len = LEN_W'(len); rsp_err = xerr; rsp_valid = 1'b1;
    tick();
    rsp_valid = 1'b0; rsp_err = 1'b0;
  endtask

  task automatic query(input logic [15:0] v, input logic [7:0] t, input bit exp, input string tag);
    qry_vid = v; qry_type = t;
    @(posedge clk); @(negedge clk);
    check(hit == exp, tag, "lookup hit", hit, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!done && !err && !hit && !req_valid && proto_count == 0, "R1", "reset state",
          {done, err, hit, req_valid, 4'(proto_count)}, 0);

    // chained walk 0 -> 2 -> 5 -> end
    pulse_start();
    @(negedge clk);
    check(req_vid == 16'h0001 && req_type == 8'h00, "R2", "request header", {req_vid, req_type}, 24'h000100);
    answer(mk(16'h0001, 8'h00, 8'd2), 1, 0, 8'd0, "R2");
    answer(mk(16'h1E98, 8'h02, 8'd5), 1, 0, 8'd2, "R4");
    answer(mk(16'hABCD, 8'h07, 8'd0), 1, 0, 8'd5, "R4");
    @(negedge clk);
    check(done && !err, "R4", "walk ends on next 0", {done, err}, 2'b10);
    check(proto_count == 3, "R3", "stored three", proto_count, 3);
    tick(); tick();
    check(!req_valid, "R4", "no request after end", req_valid, 0);

    query(16'hABCD, 8'h07, 1, "R8");
    query(16'hABCD, 8'h08, 0, "R8");
    query(16'h1E98, 8'h02, 1, "R3");
    query(16'h1234, 8'h07, 0, "R8");
    query(16'h0001, 8'h00, 1, "R9");

    // stray response while idle
    rsp_word = mk(16'h5555, 8'h09, 8'd0); rsp_len = 1; rsp_valid = 1'b1; tick(); rsp_valid = 1'b0;
    @(negedge clk);
    check(proto_count == 3 && done, "R11", "idle response ignored", proto_count, 3);
    query(16'h5555, 8'h09, 0, "R11");

    // restart, with stray start and stray response mid-walk
    pulse_start();
    @(negedge clk);
    check(proto_count == 0 && !done && !err, "R10", "restart clears", {done, err, 4'(proto_count)}, 0);
    query(16'h0001, 8'h00, 1, "R9");
    query(16'hABCD, 8'h07, 0, "R10");
    rsp_word = mk(16'h7777, 8'h01, 8'd0); rsp_len = 1; rsp_valid = 1'b1; tick(); rsp_valid = 1'b0;
    pulse_start();
    answer(mk(16'h0001, 8'h00, 8'd3), 1, 0, 8'd0, "R10");
    pulse_start();
    answer(mk(16'h00C1, 8'h04, 8'd0), 1, 0, 8'd3, "R10");
    @(negedge clk);
    check(done && proto_count == 2, "R10", "walk unaffected by stray start", proto_count, 2);
    query(16'h7777, 8'h01, 0, "R11");

    // bad length
    pulse_start();
    answer(mk(16'h0001, 8'h00, 8'd1), 1, 0, 8'd0, "R5");
    answer(mk(16'h0ACE, 8'h01, 8'd2), 2, 0, 8'd1, "R5");
    @(negedge clk);
    check(err && !done && proto_count == 1, "R5", "length error", {err, done, 4'(proto_count)}, 6'h21);
    tick(); tick();
    check(!req_valid, "R5", "walk stopped", req_valid, 0);
    query(16'h0ACE, 8'h01, 0, "R5");

    // transport error
    pulse_start();
    answer(mk(16'h0001, 8'h00, 8'd4), 1, 0, 8'd0, "R6");
    answer(mk(16'h0BEE, 8'h03, 8'd0), 1, 1, 8'd4, "R6");
    @(negedge clk);
    check(err && !done && proto_count == 1, "R6", "transport error", {err, done, 4'(proto_count)}, 6'h21);
    query(16'h0BEE, 8'h03, 0, "R6");

    // overflow: chain one longer than the table
    pulse_start();
    answer(mk(16'h0001, 8'h00, 8'd1), 1, 0, 8'd0, "R7");
    answer(mk(16'h0101, 8'h11, 8'd2), 1, 0, 8'd1, "R7");
    answer(mk(16'h0202, 8'h22, 8'd3), 1, 0, 8'd2, "R7");
    answer(mk(16'h0303, 8'h33, 8'd4), 1, 0, 8'd3, "R7");
    @(negedge clk);
    check(proto_count == TB_DEPTH && !err, "R7", "table full", proto_count, TB_DEPTH);
    answer(mk(16'h0404, 8'h44, 8'd0), 1, 0, 8'd4, "R7");
    @(negedge clk);
    check(err && !done && proto_count == TB_DEPTH, "R7", "overflow", {err, done, 4'(proto_count)}, {2'b10, 4'(TB_DEPTH)});
    query(16'h0303, 8'h33, 1, "R8");
    query(16'h0404, 8'h44, 0, "R7");

    tick(); tick();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule